// File: doc/BRIEF.md
# Dual-Oscillator Clock Mode Controller

This block decides which of two oscillators clocks the CPU and when either oscillator runs. The slow oscillator is always available. The fast oscillator can be powered down to save energy. Software drives two level bits. The first powers the fast oscillator. The second asks for the CPU clock to come from the fast oscillator. The controller only honours the second bit once a settling counter, clocked by slow-clock ticks, reports that the fast oscillator is stable.

The block also handles two standby states, entered on one-cycle strobes. HALT stops the CPU clock and leaves both oscillators as they were. SLEEP stops the CPU clock and both oscillators. On leaving standby, the controller returns to the run mode that was active before. After SLEEP, a fast oscillator that was in use is powered back up and settled again before the CPU is moved onto it. A 3-bit code on the outputs reports the current mode.

Top module: `dual_osc_clkctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the block is in low-power mode: `mode_code`=0, `fast_osc_en`=0, `slow_osc_en`=1, `cpu_clk_gate`=1, `cpu_sel_fast`=0, `fast_stable`=0.
- R2: In run mode with the CPU on the slow clock, `fast_osc_en` follows `fast_en_bit` one cycle later.
- R3: In run mode, `sel_fast_bit`=1 sets `cpu_sel_fast` one cycle after a cycle in which the fast oscillator is on and `fast_stable`=1. Until then the request stays pending. `sel_fast_bit`=0 clears `cpu_sel_fast` one cycle later.
- R4: Whenever `fast_osc_en` rises, a counter loads SETTLE_TICKS and counts down on each cycle with `slow_tick`=1. `fast_stable` is 1 exactly while `fast_osc_en`=1 and the count is zero, so it drops in the same cycle that `fast_osc_en` falls.
- R5: While `cpu_sel_fast`=1, `fast_en_bit`=0 leaves `fast_osc_en` at 1. After `cpu_sel_fast` falls, the fast oscillator stays on for one more cycle, then follows `fast_en_bit`.
- R6: From run mode, `halt_evt` leads one cycle later to HALT. In HALT, `cpu_clk_gate`=0, `slow_osc_en`=1, and `fast_osc_en` and `cpu_sel_fast` keep their values.
- R7: From run mode, `sleep_evt` leads one cycle later to SLEEP. In SLEEP, `cpu_clk_gate`=0, `slow_osc_en`=0, `fast_osc_en`=0 and `cpu_sel_fast`=0. If `sleep_evt` and `halt_evt` arrive in the same cycle, SLEEP is entered.
- R8: HALT is left one cycle after `irq_evt` or `wake_irq_evt`. SLEEP is left only one cycle after `wake_irq_evt`, and `irq_evt` alone has no effect on it. Software bits are ignored during standby.
- R9: Leaving HALT restores the exact run outputs. Leaving SLEEP from a mode that used the fast oscillator powers the fast oscillator again with `cpu_sel_fast`=0. It then settles the full SETTLE_TICKS before a still-set `sel_fast_bit` reselects the fast clock.
- R10: `mode_code` reads 0 for low-power, 1 for slow clock with the fast oscillator on, 2 for CPU on the fast clock, 3 for HALT and 4 for SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| fast_en_bit | input | 1 | Software bit: power the fast oscillator |
| sel_fast_bit | input | 1 | Software bit: clock the CPU from the fast oscillator |
| halt_evt | input | 1 | Strobe: enter HALT |
| sleep_evt | input | 1 | Strobe: enter SLEEP |
| irq_evt | input | 1 | Strobe: any interrupt (leaves HALT) |
| wake_irq_evt | input | 1 | Strobe: input interrupt (leaves HALT or SLEEP) |
| fast_osc_en | output | 1 | Fast oscillator power enable |
| slow_osc_en | output | 1 | Slow oscillator power enable |
| cpu_sel_fast | output | 1 | CPU clock source select, 1 = fast |
| cpu_clk_gate | output | 1 | CPU clock enable, 0 in standby |
| fast_stable | output | 1 | Fast oscillator has settled |
| mode_code | output | 3 | Current mode code |

## Verification
Several events can land in the same cycle. A pending fast-clock request can be granted in the very cycle that a halt or sleep strobe arrives. A sleep strobe can coincide with a halt strobe. A plain interrupt can coincide with SLEEP, where it must be ignored. The bench drives directed cases for sleep together with halt, and for an interrupt during SLEEP. Random runs then hit the other overlaps, with the software bits and the strobes flipping freely while the settling count is near zero. Each cycle, every output is compared with an independent cycle model built from the requirements. That model gives standby entry priority over a same-cycle clock switch.

// File: rtl/dosc_pkg.sv
package dosc_pkg;

    typedef enum logic [2:0] {
        MC_LOWPWR = 3'd0,
        MC_LOWSPD = 3'd1,
        MC_HISPD  = 3'd2,
        MC_HALT   = 3'd3,
        MC_SLEEP  = 3'd4
    } mode_code_e;

    typedef enum logic [1:0] {
        SB_RUN   = 2'd0,
        SB_HALT  = 2'd1,
        SB_SLEEP = 2'd2
    } standby_e;

    // Run-mode configuration kept across standby
    typedef struct packed {
        logic fast_on;   // fast oscillator powered in run mode
        logic on_fast;   // CPU clocked from fast oscillator
    } run_cfg_t;

    // Requests sampled each cycle
    typedef struct packed {
        logic fast_en;
        logic sel_fast;
        logic halt;
        logic sleep;
        logic irq;
        logic wake_irq;
    } ctl_req_t;

    function automatic mode_code_e encode_mode(standby_e sb, run_cfg_t cfg);
        if (sb == SB_SLEEP)     return MC_SLEEP;
        else if (sb == SB_HALT) return MC_HALT;
        else if (cfg.on_fast)   return MC_HISPD;
        else if (cfg.fast_on)   return MC_LOWSPD;
        else                    return MC_LOWPWR;
    endfunction

endpackage

// File: rtl/dosc_settle_ctr.sv
module dosc_settle_ctr #(
    parameter int SETTLE_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_active,
    input  logic tick,
    output logic stable
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !osc_active) begin
            cnt_q <= LOAD_VAL;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign stable = osc_active && (cnt_q == '0);

endmodule

// File: rtl/dosc_mode_fsm.sv
module dosc_mode_fsm
    import dosc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_req_t req,
    input  logic     stable,
    output standby_e sb,
    output run_cfg_t cfg
);
    standby_e sb_q, sb_n;
    run_cfg_t cfg_q, cfg_n;

    always_comb begin
        sb_n  = sb_q;
        cfg_n = cfg_q;
        unique case (sb_q)
            SB_RUN: begin
                if (req.sleep) begin
                    sb_n          = SB_SLEEP;
                    cfg_n.on_fast = 1'b0;
                end else if (req.halt) begin
                    sb_n = SB_HALT;
                end else begin
                    if (cfg_q.on_fast)
                        cfg_n.on_fast = req.sel_fast;
                    else
                        cfg_n.on_fast = req.sel_fast && cfg_q.fast_on && stable;
                    cfg_n.fast_on = req.fast_en || cfg_q.on_fast || cfg_n.on_fast;
                end
            end
            SB_HALT: begin
                if (req.irq || req.wake_irq) sb_n = SB_RUN;
            end
            SB_SLEEP: begin
                if (req.wake_irq) sb_n = SB_RUN;
            end
            default: sb_n = SB_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_q  <= SB_RUN;
            cfg_q <= '0;
        end else begin
            sb_q  <= sb_n;
            cfg_q <= cfg_n;
        end
    end

    assign sb  = sb_q;
    assign cfg = cfg_q;

endmodule

// File: rtl/dosc_out_decode.sv
module dosc_out_decode
    import dosc_pkg::*;
(
    input  standby_e   sb,
    input  run_cfg_t   cfg,
    output logic       fast_osc_en,
    output logic       slow_osc_en,
    output logic       cpu_sel_fast,
    output logic       cpu_clk_gate,
    output logic [2:0] mode_code
);
    assign fast_osc_en  = cfg.fast_on && (sb != SB_SLEEP);
    assign slow_osc_en  = (sb != SB_SLEEP);
    assign cpu_sel_fast = cfg.on_fast;
    assign cpu_clk_gate = (sb == SB_RUN);
    assign mode_code    = encode_mode(sb, cfg);

endmodule

// File: rtl/dual_osc_clkctl.sv
module dual_osc_clkctl
    import dosc_pkg::*;
#(
    parameter int SETTLE_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_tick,
    input  logic       fast_en_bit,
    input  logic       sel_fast_bit,
    input  logic       halt_evt,
    input  logic       sleep_evt,
    input  logic       irq_evt,
    input  logic       wake_irq_evt,
    output logic       fast_osc_en,
    output logic       slow_osc_en,
    output logic       cpu_sel_fast,
    output logic       cpu_clk_gate,
    output logic       fast_stable,
    output logic [2:0] mode_code
);
    ctl_req_t req;
    standby_e sb;
    run_cfg_t cfg;

    assign req = '{fast_en: fast_en_bit, sel_fast: sel_fast_bit, halt: halt_evt,
                   sleep: sleep_evt, irq: irq_evt, wake_irq: wake_irq_evt};

    dosc_mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .stable (fast_stable),
        .sb     (sb),
        .cfg    (cfg)
    );

    dosc_settle_ctr #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk        (clk),
        .rst        (rst),
        .osc_active (fast_osc_en),
        .tick       (slow_tick),
        .stable     (fast_stable)
    );

    dosc_out_decode u_dec (
        .sb           (sb),
        .cfg          (cfg),
        .fast_osc_en  (fast_osc_en),
        .slow_osc_en  (slow_osc_en),
        .cpu_sel_fast (cpu_sel_fast),
        .cpu_clk_gate (cpu_clk_gate),
        .mode_code    (mode_code)
    );

endmodule

// File: rtl/dosc_checker.sv
module dosc_checker (
    input logic       clk,
    input logic       rst,
    input logic       irq_evt,
    input logic       wake_irq_evt,
    input logic       fast_osc_en,
    input logic       slow_osc_en,
    input logic       cpu_sel_fast,
    input logic       cpu_clk_gate,
    input logic       fast_stable,
    input logic [2:0] mode_code
);
    assert_reset_lowpwr_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_code == 3'd0 && !fast_osc_en && slow_osc_en && cpu_clk_gate));

    assert_fast_needs_stable_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_sel_fast |-> fast_stable);

    assert_stable_needs_osc_R4: assert property (@(posedge clk) disable iff (rst)
        fast_stable |-> fast_osc_en);

    assert_osc_kept_while_sel_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_sel_fast |-> fast_osc_en);

    assert_halt_keeps_osc_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd3) |-> (slow_osc_en && !cpu_clk_gate && $stable(fast_osc_en)));

    assert_sleep_all_off_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 3'd4) |-> (!slow_osc_en && !fast_osc_en && !cpu_clk_gate && !cpu_sel_fast));

    assert_sleep_exit_wake_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_code) == 3'd4 && mode_code != 3'd4) |-> $past(wake_irq_evt));

    assert_halt_exit_irq_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_code) == 3'd3 && mode_code != 3'd3) |-> ($past(irq_evt) || $past(wake_irq_evt)));

    assert_code_range_R10: assert property (@(posedge clk) disable iff (rst)
        mode_code <= 3'd4);

endmodule

bind dual_osc_clkctl dosc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_evt      (irq_evt),
    .wake_irq_evt (wake_irq_evt),
    .fast_osc_en  (fast_osc_en),
    .slow_osc_en  (slow_osc_en),
    .cpu_sel_fast (cpu_sel_fast),
    .cpu_clk_gate (cpu_clk_gate),
    .fast_stable  (fast_stable),
    .mode_code    (mode_code)
);

// File: tb/tb_dual_osc_clkctl.sv
`timescale 1ns/1ps
module tb_dual_osc_clkctl;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1, slow_tick = 1'b0, fast_en_bit = 1'b0, sel_fast_bit = 1'b0;
    logic halt_evt = 1'b0, sleep_evt = 1'b0, irq_evt = 1'b0, wake_irq_evt = 1'b0;
    logic fast_osc_en, slow_osc_en, cpu_sel_fast, cpu_clk_gate, fast_stable;
    logic [2:0] mode_code;

    dual_osc_clkctl #(.SETTLE_TICKS(SETTLE)) dut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .fast_en_bit(fast_en_bit),
        .sel_fast_bit(sel_fast_bit), .halt_evt(halt_evt), .sleep_evt(sleep_evt),
        .irq_evt(irq_evt), .wake_irq_evt(wake_irq_evt), .fast_osc_en(fast_osc_en),
        .slow_osc_en(slow_osc_en), .cpu_sel_fast(cpu_sel_fast), .cpu_clk_gate(cpu_clk_gate),
        .fast_stable(fast_stable), .mode_code(mode_code));

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state: standby 0 run, 1 halt, 2 sleep
    bit m_fast_on = 0, m_on_fast = 0;
    int m_sb = 0, m_cnt = SETTLE;

    function automatic int exp_fast();   return (m_fast_on && m_sb != 2) ? 1 : 0; endfunction
    function automatic int exp_stable(); return (exp_fast() == 1 && m_cnt == 0) ? 1 : 0; endfunction
    function automatic int exp_mode();
        if (m_sb == 2) return 4;
        if (m_sb == 1) return 3;
        if (m_on_fast) return 2;
        if (m_fast_on) return 1;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 fast_osc_en",  int'(fast_osc_en),  exp_fast());
        chk("R7 slow_osc_en",  int'(slow_osc_en),  (m_sb != 2) ? 1 : 0);
        chk("R3 cpu_sel_fast", int'(cpu_sel_fast), int'(m_on_fast));
        chk("R6 cpu_clk_gate", int'(cpu_clk_gate), (m_sb == 0) ? 1 : 0);
        chk("R4 fast_stable",  int'(fast_stable),  exp_stable());
        chk("R10 mode_code",   int'(mode_code),    exp_mode());
    endtask

    task automatic step(input bit r, input bit fe, input bit fs, input bit h,
                        input bit s, input bit i, input bit w, input bit t);
        bit act, stab, n_on_fast;
        rst = r; fast_en_bit = fe; sel_fast_bit = fs; halt_evt = h;
        sleep_evt = s; irq_evt = i; wake_irq_evt = w; slow_tick = t;
        if (r) begin
            m_fast_on = 0; m_on_fast = 0; m_sb = 0; m_cnt = SETTLE;
        end else begin
            act  = (exp_fast() == 1);
            stab = (exp_stable() == 1);
            if (!act) m_cnt = SETTLE;
            else if (t && m_cnt != 0) m_cnt = m_cnt - 1;
            if (m_sb == 0) begin
                if (s) begin m_sb = 2; m_on_fast = 0; end
                else if (h) m_sb = 1;
                else begin
                    n_on_fast = m_on_fast ? fs : (fs && m_fast_on && stab);
                    m_fast_on = fe || m_on_fast || n_on_fast;
                    m_on_fast = n_on_fast;
                end
            end else if (m_sb == 1) begin
                if (i || w) m_sb = 0;
            end else begin
                if (w) m_sb = 0;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1,0,0,0,0,0,0,0); step(1,0,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,0);
        chk("R1 mode", int'(mode_code), 0);
        chk("R1 fast", int'(fast_osc_en), 0);
        chk("R1 slow", int'(slow_osc_en), 1);
        // R3: select pending while fast oscillator off
        step(0,0,1,0,0,0,0,1);
        chk("R3 pending off", int'(cpu_sel_fast), 0);
        // R2/R4: enable and settle
        step(0,1,1,0,0,0,0,1);
        chk("R2 mode1", int'(mode_code), 1);
        repeat (SETTLE-1) step(0,1,1,0,0,0,0,1);
        chk("R4 not yet stable", int'(fast_stable), 0);
        step(0,1,1,0,0,0,0,1);
        chk("R4 stable", int'(fast_stable), 1);
        chk("R3 pending until stable", int'(cpu_sel_fast), 0);
        step(0,1,1,0,0,0,0,1);
        chk("R3 high speed", int'(mode_code), 2);
        // R5: clearing enable ignored while fast selected
        step(0,0,1,0,0,0,0,1);
        chk("R5 enable kept", int'(fast_osc_en), 1);
        step(0,0,0,0,0,0,0,1);
        chk("R5 changeover", int'(mode_code), 1);
        step(0,0,0,0,0,0,0,1);
        chk("R5 osc off after", int'(fast_osc_en), 0);
        chk("R4 stable drops", int'(fast_stable), 0);
        // R6/R8/R9: halt from high speed
        repeat (SETTLE+2) step(0,1,1,0,0,0,0,1);
        chk("R3 high speed again", int'(mode_code), 2);
        step(0,1,1,1,0,0,0,1);
        chk("R6 halt", int'(mode_code), 3);
        chk("R6 fast kept", int'(fast_osc_en), 1);
        step(0,0,0,0,0,1,0,1);
        chk("R9 resume halt", int'(mode_code), 2);
        // R7/R8: sleep wins over halt; plain irq ignored in sleep
        step(0,1,1,1,1,0,0,1);
        chk("R7 sleep wins", int'(mode_code), 4);
        chk("R7 fast off", int'(fast_osc_en), 0);
        step(0,1,1,0,0,1,0,1);
        chk("R8 irq ignored in sleep", int'(mode_code), 4);
        step(0,1,1,0,0,0,1,1);
        chk("R9 wake slow first", int'(mode_code), 1);
        chk("R9 restart settle", int'(fast_stable), 0);
        repeat (SETTLE) step(0,1,1,0,0,0,0,1);
        chk("R9 still slow", int'(cpu_sel_fast), 0);
        step(0,1,1,0,0,0,0,1);
        chk("R9 reselect fast", int'(mode_code), 2);
        // Random phase
        begin
            bit fe, fs;
            int seed_dummy;
            seed_dummy = $urandom(32'h1234);
            fe = 1; fs = 1;
            for (int n = 0; n < 4000; n++) begin
                if ($urandom_range(0, 19) == 0) fe = ~fe;
                if ($urandom_range(0, 24) == 0) fs = ~fs;
                step(0, fe, fs,
                     $urandom_range(0, 39) == 0, $urandom_range(0, 59) == 0,
                     $urandom_range(0, 9) == 0,  $urandom_range(0, 19) == 0,
                     $urandom_range(0, 1) == 1);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule